// File: doc/BRIEF.md
# Two-Phase Transmit Descriptor Queue Manager

This block keeps the state of several descriptor rings that live in host memory. For each ring it holds a base address, an enable bit, a ring size, a producer pointer written by the host and a consumer pointer that only the block advances. Host software reaches these registers through an AXI-Lite slave port. Every write of a producer pointer emits a one-cycle doorbell pulse that carries the queue index. A downstream scheduler uses that pulse to learn that the queue has work.

A dequeue takes two steps. A fetch engine sends a request that names a queue. The block replies with a status, a tag and the host DMA address of the descriptor slot to read. The slot is reserved against a shadow pointer that counts uncommitted reservations, so the same slot is never handed out twice. The consumer pointer moves only when the fetch engine later returns a commit that carries the tag. Several reservations may be outstanding at once, up to the number of tags.

The dequeue side is a two-state machine. `DQ_IDLE` accepts a request when a tag is free and moves to `DQ_EVAL`. `DQ_EVAL` judges the queue, registers the response, reserves a slot on success and always returns to `DQ_IDLE`. The register port has a write machine and a read machine. The write machine runs `W_IDLE` -> `W_RESP` on a write and goes back on `bready`. The read machine runs `R_IDLE` -> `R_DATA` on a read and goes back on `rready`.

Top module: `qm_txq_manager`

## Requirements
- R1: After reset, all registers read as zero, `req_ready` is 1, and `rsp_valid` and `db_valid` are 0.
- R2: A write to a producer pointer stores bits 15:0 and raises `db_valid` for exactly one cycle, together with the first cycle of `s_bvalid`, with `db_queue` equal to the queue index.
- R3: Queue q occupies byte offsets q*16 to q*16+15. The words are base (+0x0), control (+0x4: bit 31 enable, bits 3:0 log2 of ring size), producer (+0x8) and consumer (+0xC). The consumer word is read-only and writes to it are ignored.
- R4: A response appears as a one-cycle `rsp_valid` pulse one clock edge after the edge that accepted the request. Status codes are 0 = ok, 1 = empty, 2 = disabled. Disabled takes precedence over empty, and `rsp_queue` echoes the queue.
- R5: On success, `rsp_addr` equals base + (shadow mod ring size) * 16, where shadow counts committed plus reserved slots.
- R6: The consumer pointer stays unchanged until a commit arrives whose tag is outstanding. Such a commit raises that queue's consumer pointer by one.
- R7: A queue is empty when its shadow pointer equals its producer pointer, so reservations that are not yet committed already count as consumed.
- R8: An empty or disabled response consumes no tag and changes no pointer.
- R9: The lowest free tag is assigned. `req_ready` is 0 while every tag is outstanding, and a commit of a tag that is not outstanding is ignored.
- R10: The slot index wraps to 0 once it reaches the ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_awaddr | input | AW | Register write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | AW | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| db_valid | output | 1 | Doorbell pulse |
| db_queue | output | QW | Doorbell queue index |
| req_valid | input | 1 | Dequeue request valid |
| req_ready | output | 1 | Dequeue request accepted |
| req_queue | input | QW | Queue to dequeue from |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 empty, 2 disabled |
| rsp_queue | output | QW | Queue of this response |
| rsp_tag | output | TW | Tag reserved for this operation |
| rsp_addr | output | 32 | Host address of the descriptor slot |
| cmt_valid | input | 1 | Commit pulse |
| cmt_tag | input | TW | Tag being committed |

## Verification
The bench keeps several reservations outstanding and then asks again, so that a design judging emptiness on the committed pointer would hand out a slot that is already reserved. It takes the slot index past the ring size, where a missing mask would produce an address beyond the ring. It fills every tag, where a design that ignored the full case would overwrite a live tag. It repeats a commit for a tag that is already freed, where a careless table would bump the consumer pointer twice. It also checks that an empty or disabled reply leaves the consumer pointer alone and releases no tag, and that the consumer register ignores writes.

// File: rtl/qm_pkg.sv
package qm_pkg;
    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_EMPTY    = 2'd1,
        ST_DISABLED = 2'd2
    } dq_status_e;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_PROD = 2'd2;
    localparam logic [1:0] SEL_CONS = 2'd3;

    localparam int REG_W = 32;
endpackage

// File: rtl/qm_regfile.sv
module qm_regfile
    import qm_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int PTR_W = 16,
    parameter int QW    = $clog2(NQ),
    parameter int AW    = QW + 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        s_awvalid,
    output logic                        s_awready,
    input  logic [AW-1:0]               s_awaddr,
    input  logic                        s_wvalid,
    output logic                        s_wready,
    input  logic [REG_W-1:0]            s_wdata,
    input  logic [3:0]                  s_wstrb,
    output logic                        s_bvalid,
    input  logic                        s_bready,
    input  logic                        s_arvalid,
    output logic                        s_arready,
    input  logic [AW-1:0]               s_araddr,
    output logic                        s_rvalid,
    input  logic                        s_rready,
    output logic [REG_W-1:0]            s_rdata,
    output logic                        db_valid,
    output logic [QW-1:0]               db_queue,
    input  logic                        shadow_inc,
    input  logic [QW-1:0]               shadow_qsel,
    input  logic                        cons_inc,
    input  logic [QW-1:0]               cons_qsel,
    output logic [NQ-1:0][REG_W-1:0]    base_o,
    output logic [NQ-1:0]               en_o,
    output logic [NQ-1:0][3:0]          lsz_o,
    output logic [NQ-1:0][PTR_W-1:0]    prod_o,
    output logic [NQ-1:0][PTR_W-1:0]    shadow_o
);
    typedef enum logic {W_IDLE, W_RESP} wr_state_e;
    typedef enum logic {R_IDLE, R_DATA} rd_state_e;

    wr_state_e wr_st, wr_nx;
    rd_state_e rd_st, rd_nx;

    logic [NQ-1:0][REG_W-1:0] base_r;
    logic [NQ-1:0]            en_r;
    logic [NQ-1:0][3:0]       lsz_r;
    logic [NQ-1:0][PTR_W-1:0] prod_r;
    logic [NQ-1:0][PTR_W-1:0] cons_r;
    logic [NQ-1:0][PTR_W-1:0] shadow_r;
    logic [REG_W-1:0]         rdata_r;
    logic [REG_W-1:0]         wmerged;

    logic          wr_fire, rd_fire;
    logic [QW-1:0] wq, rq;
    logic [1:0]    wsel, rsel;
    logic          unused_addr_bits;

    assign wq   = s_awaddr[4 +: QW];
    assign wsel = s_awaddr[3:2];
    assign rq   = s_araddr[4 +: QW];
    assign rsel = s_araddr[3:2];
    assign unused_addr_bits = ^{s_awaddr[1:0], s_araddr[1:0]};

    function automatic logic [REG_W-1:0] rd_word(input logic [QW-1:0] q, input logic [1:0] sel);
        logic [REG_W-1:0] w;
        unique case (sel)
            SEL_BASE: w = base_r[q];
            SEL_CTRL: w = {en_r[q], 27'd0, lsz_r[q]};
            SEL_PROD: w = REG_W'(prod_r[q]);
            default:  w = REG_W'(cons_r[q]);
        endcase
        return w;
    endfunction

    // byte-lane merge of new write data into the current word
    always_comb begin
        logic [REG_W-1:0] old;
        old = rd_word(wq, wsel);
        for (int b = 0; b < 4; b++)
            wmerged[8*b +: 8] = s_wstrb[b] ? s_wdata[8*b +: 8] : old[8*b +: 8];
    end

    // write channel: address and data are taken together
    assign wr_fire   = (wr_st == W_IDLE) && s_awvalid && s_wvalid;
    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_bvalid  = (wr_st == W_RESP);

    always_comb begin
        wr_nx = wr_st;
        unique case (wr_st)
            W_IDLE: if (wr_fire) wr_nx = W_RESP;
            W_RESP: if (s_bready) wr_nx = W_IDLE;
        endcase
    end

    // read channel
    assign rd_fire   = (rd_st == R_IDLE) && s_arvalid;
    assign s_arready = (rd_st == R_IDLE);
    assign s_rvalid  = (rd_st == R_DATA);
    assign s_rdata   = rdata_r;

    always_comb begin
        rd_nx = rd_st;
        unique case (rd_st)
            R_IDLE: if (s_arvalid) rd_nx = R_DATA;
            R_DATA: if (s_rready) rd_nx = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_st <= W_IDLE;
            rd_st <= R_IDLE;
        end else begin
            wr_st <= wr_nx;
            rd_st <= rd_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_r  <= '0;
            db_valid <= 1'b0;
            db_queue <= '0;
        end else begin
            if (rd_fire) rdata_r <= rd_word(rq, rsel);
            db_valid <= wr_fire && (wsel == SEL_PROD);
            db_queue <= wq;
        end
    end

    // per-queue storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r   <= '0;
            en_r     <= '0;
            lsz_r    <= '0;
            prod_r   <= '0;
            cons_r   <= '0;
            shadow_r <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (shadow_inc && shadow_qsel == QW'(q)) shadow_r[q] <= shadow_r[q] + 1'b1;
                if (cons_inc && cons_qsel == QW'(q))     cons_r[q]   <= cons_r[q] + 1'b1;
            end
            if (wr_fire) begin
                unique case (wsel)
                    SEL_BASE: base_r[wq] <= wmerged;
                    SEL_CTRL: begin
                        en_r[wq]  <= wmerged[31];
                        lsz_r[wq] <= wmerged[3:0];
                    end
                    SEL_PROD: prod_r[wq] <= wmerged[PTR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign base_o   = base_r;
    assign en_o     = en_r;
    assign lsz_o    = lsz_r;
    assign prod_o   = prod_r;
    assign shadow_o = shadow_r;
endmodule

// File: rtl/qm_op_table.sv
module qm_op_table #(
    parameter int TAGS = 4,
    parameter int QW   = 2,
    parameter int TW   = $clog2(TAGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [QW-1:0] alloc_q,
    input  logic          cmt_valid,
    input  logic [TW-1:0] cmt_tag,
    output logic          free_any,
    output logic [TW-1:0] free_tag,
    output logic          cmt_hit,
    output logic [QW-1:0] cmt_q
);
    logic [TAGS-1:0]          busy;
    logic [TAGS-1:0][QW-1:0]  owner;

    // lowest free tag wins
    always_comb begin
        free_any = 1'b0;
        free_tag = '0;
        for (int t = TAGS - 1; t >= 0; t--) begin
            if (!busy[t]) begin
                free_any = 1'b1;
                free_tag = TW'(t);
            end
        end
    end

    assign cmt_hit = cmt_valid && busy[cmt_tag];
    assign cmt_q   = owner[cmt_tag];

    generate
        for (genvar t = 0; t < TAGS; t++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy[t]  <= 1'b0;
                    owner[t] <= '0;
                end else if (alloc && free_tag == TW'(t)) begin
                    busy[t]  <= 1'b1;
                    owner[t] <= alloc_q;
                end else if (cmt_valid && cmt_tag == TW'(t)) begin
                    busy[t]  <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/qm_txq_manager.sv
module qm_txq_manager
    import qm_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int PTR_W    = 16,
    parameter int TAGS     = 4,
    parameter int DESC_LOG = 4,
    parameter int QW       = $clog2(NQ),
    parameter int TW       = $clog2(TAGS),
    parameter int AW       = QW + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_awvalid,
    output logic             s_awready,
    input  logic [AW-1:0]    s_awaddr,
    input  logic             s_wvalid,
    output logic             s_wready,
    input  logic [31:0]      s_wdata,
    input  logic [3:0]       s_wstrb,
    output logic             s_bvalid,
    input  logic             s_bready,
    output logic [1:0]       s_bresp,
    input  logic             s_arvalid,
    output logic             s_arready,
    input  logic [AW-1:0]    s_araddr,
    output logic             s_rvalid,
    input  logic             s_rready,
    output logic [31:0]      s_rdata,
    output logic [1:0]       s_rresp,
    output logic             db_valid,
    output logic [QW-1:0]    db_queue,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [QW-1:0]    req_queue,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [QW-1:0]    rsp_queue,
    output logic [TW-1:0]    rsp_tag,
    output logic [31:0]      rsp_addr,
    input  logic             cmt_valid,
    input  logic [TW-1:0]    cmt_tag
);
    typedef enum logic {DQ_IDLE, DQ_EVAL} dq_state_e;

    dq_state_e dst, dnx;

    logic [NQ-1:0][REG_W-1:0] base_w;
    logic [NQ-1:0]            en_w;
    logic [NQ-1:0][3:0]       lsz_w;
    logic [NQ-1:0][PTR_W-1:0] prod_w;
    logic [NQ-1:0][PTR_W-1:0] shadow_w;

    logic          free_any, cmt_hit, alloc;
    logic [TW-1:0] free_tag;
    logic [QW-1:0] cmt_q, cur_q;
    dq_status_e    verdict;
    logic [PTR_W-1:0] mask, slot;
    logic [31:0]   slot_addr;

    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

    qm_regfile #(.NQ(NQ), .PTR_W(PTR_W), .QW(QW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
        .db_valid(db_valid), .db_queue(db_queue),
        .shadow_inc(alloc), .shadow_qsel(cur_q),
        .cons_inc(cmt_hit), .cons_qsel(cmt_q),
        .base_o(base_w), .en_o(en_w), .lsz_o(lsz_w),
        .prod_o(prod_w), .shadow_o(shadow_w)
    );

    qm_op_table #(.TAGS(TAGS), .QW(QW), .TW(TW)) u_ops (
        .clk(clk), .rst_n(rst_n),
        .alloc(alloc), .alloc_q(cur_q),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
        .free_any(free_any), .free_tag(free_tag),
        .cmt_hit(cmt_hit), .cmt_q(cmt_q)
    );

    // queue evaluation, used in DQ_EVAL
    always_comb begin
        if (!en_w[cur_q])                        verdict = ST_DISABLED;
        else if (shadow_w[cur_q] == prod_w[cur_q]) verdict = ST_EMPTY;
        else                                     verdict = ST_OK;
        mask      = ~({PTR_W{1'b1}} << lsz_w[cur_q]);
        slot      = shadow_w[cur_q] & mask;
        slot_addr = base_w[cur_q] + (32'(slot) << DESC_LOG);
    end

    assign req_ready = (dst == DQ_IDLE) && free_any;
    assign alloc     = (dst == DQ_EVAL) && (verdict == ST_OK);

    always_comb begin
        dnx = dst;
        unique case (dst)
            DQ_IDLE: if (req_valid && req_ready) dnx = DQ_EVAL;
            DQ_EVAL: dnx = DQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dst <= DQ_IDLE;
        else        dst <= dnx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= '0;
            rsp_queue  <= '0;
            rsp_tag    <= '0;
            rsp_addr   <= '0;
        end else begin
            if (req_valid && req_ready) cur_q <= req_queue;
            rsp_valid <= (dst == DQ_EVAL);
            if (dst == DQ_EVAL) begin
                rsp_status <= verdict;
                rsp_queue  <= cur_q;
                rsp_tag    <= free_tag;
                rsp_addr   <= (verdict == ST_OK) ? slot_addr : 32'd0;
            end
        end
    end
endmodule

// File: rtl/qm_txq_manager_chk.sv
module qm_txq_manager_chk #(
    parameter int NQ    = 4,
    parameter int PTR_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        db_valid,
    input logic                        wr_accept,
    input logic [1:0]                  wr_sel,
    input logic                        rsp_valid,
    input logic [1:0]                  rsp_status,
    input logic [NQ-1:0][PTR_W-1:0]    shadow,
    input logic [NQ-1:0][PTR_W-1:0]    cons,
    input logic                        cmt_hit,
    input logic                        free_any,
    input logic                        req_ready
);
    p_db_from_prod_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(wr_accept && wr_sel == 2'd2));

    p_rsp_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_cons_needs_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmt_hit) |-> $stable(cons));

    p_failed_keeps_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> $stable(shadow));

    p_full_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !free_any |-> !req_ready);
endmodule

bind qm_txq_manager qm_txq_manager_chk #(.NQ(NQ), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .db_valid(db_valid),
    .wr_accept(s_awvalid && s_awready),
    .wr_sel(s_awaddr[3:2]),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .shadow(shadow_w), .cons(u_regs.cons_r),
    .cmt_hit(cmt_hit), .free_any(free_any), .req_ready(req_ready)
);

// File: tb/qm_txq_manager_tb.sv
module qm_txq_manager_tb;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
    logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = 4'hF;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic db_valid;
    logic [1:0] db_queue;
    logic req_valid = 0;
    logic [1:0] req_queue = '0;
    logic req_ready, rsp_valid;
    logic [1:0] rsp_status, rsp_queue, rsp_tag;
    logic [31:0] rsp_addr;
    logic cmt_valid = 0;
    logic [1:0] cmt_tag = '0;

    int errors = 0;
    int checks = 0;

    qm_txq_manager u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .db_valid(db_valid), .db_queue(db_queue),
        .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_queue(rsp_queue),
        .rsp_tag(rsp_tag), .rsp_addr(rsp_addr),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d,
                          output bit db_now, output logic [1:0] dbq, output bit db_later);
        @(negedge clk);
        s_awvalid = 1; s_wvalid = 1; s_awaddr = a; s_wdata = d;
        @(posedge clk); #1;
        db_now = db_valid && s_bvalid; dbq = db_queue;
        s_awvalid = 0; s_wvalid = 0;
        @(posedge clk); #1;
        db_later = db_valid;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        s_arvalid = 1; s_araddr = a;
        @(posedge clk); #1;
        s_arvalid = 0;
        d = s_rdata;
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bit x, z; logic [1:0] y;
        reg_wr(a, d, x, y, z);
    endtask

    task automatic deq(input logic [1:0] q, output logic [1:0] st, output logic [1:0] tag,
                       output logic [31:0] addr, output bit got);
        @(negedge clk);
        req_valid = 1; req_queue = q;
        @(posedge clk); #1;
        req_valid = 0;
        @(posedge clk); #1;
        got = rsp_valid && rsp_queue == q; st = rsp_status; tag = rsp_tag; addr = rsp_addr;
        @(posedge clk); #1;
    endtask

    task automatic commit(input logic [1:0] tag);
        @(negedge clk);
        cmt_valid = 1; cmt_tag = tag;
        @(posedge clk); #1;
        cmt_valid = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(req_ready == 1 && rsp_valid == 0 && db_valid == 0, "R1 reset outputs", {req_ready, rsp_valid, db_valid}, 3'b100);
        for (int i = 0; i < 4; i++) begin
            reg_rd(AW'(16 + 4 * i), d);
            check(d == 0, "R1 register reset value", d, 0);
        end
    endtask

    task automatic t_doorbell;
        bit now, later; logic [1:0] q; logic [31:0] d;
        reg_wr(6'h28, 32'h3, now, q, later);
        check(now == 1 && q == 2, "R2 doorbell with queue 2", {now, q}, 3'b110);
        check(later == 0, "R2 doorbell lasts one cycle", later, 0);
        reg_rd(6'h28, d);
        check(d == 3, "R2 producer readback", d, 3);
        reg_wr(6'h2C, 32'h7, now, q, later);
        check(now == 0, "R3 consumer write gives no doorbell", now, 0);
        reg_rd(6'h2C, d);
        check(d == 0, "R3 consumer write ignored", d, 0);
        wr(6'h24, 32'h8000_0003);
        reg_rd(6'h24, d);
        check(d == 32'h8000_0003, "R3 control layout", d, 32'h8000_0003);
    endtask

    task automatic t_disabled;
        logic [1:0] st, tg; logic [31:0] a; bit got; logic [31:0] d;
        wr(6'h18, 32'h2);
        deq(2'd1, st, tg, a, got);
        check(got == 1, "R4 response pulse timing", got, 1);
        check(st == 2, "R4 disabled status", st, 2);
        reg_rd(6'h1C, d);
        check(d == 0, "R8 disabled leaves consumer", d, 0);
    endtask

    task automatic t_two_phase;
        logic [1:0] st, tg; logic [31:0] a, d; bit got;
        wr(6'h00, 32'h1000);
        wr(6'h04, 32'h8000_0002);
        wr(6'h08, 32'd6);
        deq(2'd0, st, tg, a, got);
        check(got && st == 0 && tg == 0, "R9 first tag is 0", {st, tg}, 0);
        check(a == 32'h1000, "R5 slot 0 address", a, 32'h1000);
        deq(2'd0, st, tg, a, got);
        check(tg == 1 && a == 32'h1010, "R5 slot 1 address tag 1", a, 32'h1010);
        reg_rd(6'h0C, d);
        check(d == 0, "R6 consumer waits for commit", d, 0);
        commit(2'd0);
        reg_rd(6'h0C, d);
        check(d == 1, "R6 commit advances consumer", d, 1);
        commit(2'd0);
        reg_rd(6'h0C, d);
        check(d == 1, "R9 stale commit ignored", d, 1);
    endtask

    task automatic t_wrap_full_empty;
        logic [1:0] st, tg; logic [31:0] a, d; bit got;
        deq(2'd0, st, tg, a, got);
        check(tg == 0 && a == 32'h1020, "R9 freed tag reused", a, 32'h1020);
        deq(2'd0, st, tg, a, got);
        check(tg == 2 && a == 32'h1030, "R5 slot 3 address", a, 32'h1030);
        deq(2'd0, st, tg, a, got);
        check(st == 0 && tg == 3 && a == 32'h1000, "R10 index wraps to slot 0", a, 32'h1000);
        @(negedge clk);
        check(req_ready == 0, "R9 all tags busy blocks requests", req_ready, 0);
        commit(2'd1); commit(2'd0); commit(2'd2); commit(2'd3);
        reg_rd(6'h0C, d);
        check(d == 5, "R6 four commits", d, 5);
        deq(2'd0, st, tg, a, got);
        check(st == 0 && tg == 0 && a == 32'h1010, "R7 slot 5 handed out", a, 32'h1010);
        deq(2'd0, st, tg, a, got);
        check(got && st == 1, "R7 empty against reserved slot", st, 1);
        reg_rd(6'h0C, d);
        check(d == 5, "R8 empty leaves consumer", d, 5);
        commit(2'd0);
        reg_rd(6'h0C, d);
        check(d == 6, "R6 last commit", d, 6);
        deq(2'd0, st, tg, a, got);
        check(st == 1 && tg == 0, "R8 empty reply consumed no tag", {st, tg}, 3'b100);
        wr(6'h08, 32'd7);
        deq(2'd0, st, tg, a, got);
        check(st == 0 && tg == 0 && a == 32'h1020, "R10 slot 6 after new producer", a, 32'h1020);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_doorbell();
        t_disabled();
        t_two_phase();
        t_wrap_full_empty();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule